// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Serial-Peripheral Override

This block is one general-purpose I/O port of eight pins. Software reaches it through a small register bus with three registers: an output latch, a direction mask and a pull-up enable mask. For each pin the block drives an output enable, an output value and a pull-up enable toward the pad. It samples the pad level through a two-flop synchroniser, and that sampled level feeds both register readback and the attached serial-peripheral (SPI) unit.

The SPI unit can take over any pin. While the peripheral is enabled and claims a pin, the peripheral sets that pin's enable and value, and the direction register no longer drives the pad for it. The pin that carries the slave-select input has a fixed rule. It is forced to an input only while the peripheral is enabled in slave mode. At all other times it is plain GPIO. Reading the data register gives, for each bit, the latch value when the direction bit is 1 and the synchronised pin level when it is 0. This holds even on pins the peripheral has claimed.

The register bus accepts one access per cycle and never stalls, so it has no ready signal and no back-pressure. Writes complete at the clock edge that samples them. Each read produces a one-cycle `bus_rvalid` pulse on the following cycle, carrying the data.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the latch, direction and pull-up registers are all 0. As a result pad_oe, pad_out and pad_pu are 0, and reading the direction (address 1) or pull-up (address 2) register returns 0.
- R2: On a pin the peripheral does not hold, pad_oe equals the direction bit and pad_out equals the latch bit. A direction bit of 1 turns the driver on and 0 turns it off.
- R3: Reading address 0 returns, per bit, the latch bit where the direction bit is 1 and the synchronised pin level where it is 0. This applies on claimed pins as well.
- R4: A write to address 0 updates the latch even when the pin is an input, and pad_out shows the new value while pad_oe stays 0. If the direction bit is written to 1 later, the preloaded value is driven from the first cycle the driver is on.
- R5: On any pin other than the slave-select pin, when spi_en=1 and spi_claim is set for that pin, pad_oe takes spi_oe and pad_out takes spi_out. The direction bit is ignored.
- R6: Pin SELECT_PIN (default 0) is forced to pad_oe=0 whenever spi_en=1 and spi_master=0, whatever its direction bit, spi_oe and spi_claim say. With spi_en=0 or spi_master=1 it behaves as in R2.
- R7: pad_pu for a pin is its pull-up bit ANDed with the inverse of that pin's final pad_oe, so a pull-up is never on for a driven pin.
- R8: A change on pad_in reaches spi_in exactly two rising edges later. One edge after the change, spi_in still shows the old value.
- R9: A read request is answered with bus_rvalid=1 on the next cycle only. bus_rvalid is 0 on cycles that follow no read. Address 3 reads as 0, and writes to it change no register.
- R10: Writes to address 1 and address 2 are read back unchanged from the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data latch, 1 direction, 2 pull-up, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| spi_en | input | 1 | Peripheral enable |
| spi_master | input | 1 | Peripheral is master (1) or slave (0) |
| spi_claim | input | 8 | Pins the peripheral takes when enabled |
| spi_oe | input | 8 | Peripheral driver enable for claimed pins |
| spi_out | input | 8 | Peripheral output value for claimed pins |
| spi_in | output | 8 | Synchronised pad levels for the peripheral |

## Verification
Most state errors show up at the pads within the same cycle. A wrong direction or latch bit changes pad_oe, pad_out or pad_pu as soon as the register updates. A wrong override decision flips a pad enable as soon as the SPI inputs change. A wrong readback selection only shows on the next read, one cycle after the request, when some bit's direction makes the latch and the pin disagree. A synchroniser with the wrong depth shows on spi_in one edge early or late, so the bench samples on both of those edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_PULL  = 2'd2,
    REG_SPARE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_d,
  output logic [WIDTH-1:0] sync_q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= async_d;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]      bus_wdata,
  input  logic [WIDTH-1:0]      pin_sync,
  output logic [WIDTH-1:0]      latch_q,
  output logic [WIDTH-1:0]      dir_q,
  output logic [WIDTH-1:0]      pull_q,
  output logic                  rd_valid,
  output logic [WIDTH-1:0]      rd_data
);
  gpio_reg_e        sel;
  logic             wr_en, rd_en;
  logic [WIDTH-1:0] data_view;
  logic [WIDTH-1:0] rd_mux;

  assign sel   = gpio_reg_e'(bus_addr);
  assign wr_en = bus_valid & bus_we;
  assign rd_en = bus_valid & ~bus_we;

  // Per-bit readback source: the latch for outputs, the pin for inputs.
  for (genvar b = 0; b < WIDTH; b++) begin : g_view
    assign data_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
  end

  always_comb begin
    unique case (sel)
      REG_LATCH: rd_mux = data_view;
      REG_DIR:   rd_mux = dir_q;
      REG_PULL:  rd_mux = pull_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      dir_q    <= '0;
      pull_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (wr_en) begin
        unique case (sel)
          REG_LATCH: latch_q <= bus_wdata;
          REG_DIR:   dir_q   <= bus_wdata;
          REG_PULL:  pull_q  <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end

  // R9: every read is answered on the next cycle, and only then.
  p_rd_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == REG_SPARE) |=> rd_data == '0);
  // R4: the latch takes the written value regardless of direction.
  p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == REG_LATCH) |=> latch_q == $past(bus_wdata));
  // R10: direction only moves on a write to its address.
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == REG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SELECT_PIN = 0
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic             per_en,
  input  logic             per_master,
  input  logic [WIDTH-1:0] per_claim,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == SELECT_PIN) begin : g_select
      logic slave_hold;
      logic unused_sel_ovr;
      assign slave_hold     = per_en & ~per_master;
      assign unused_sel_ovr = per_claim[i] ^ per_oe[i] ^ per_out[i];
      assign pad_oe[i]      = slave_hold ? 1'b0 : dir_q[i];
      assign pad_out[i]     = latch_q[i];
    end else begin : g_plain
      logic taken;
      assign taken      = per_en & per_claim[i];
      assign pad_oe[i]  = taken ? per_oe[i]  : dir_q[i];
      assign pad_out[i] = taken ? per_out[i] : latch_q[i];
    end
  end

  assign pad_pu = pull_q & ~pad_oe;
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SELECT_PIN  = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]      bus_wdata,
  output logic                  bus_rvalid,
  output logic [WIDTH-1:0]      bus_rdata,
  input  logic [WIDTH-1:0]      pad_in,
  output logic [WIDTH-1:0]      pad_oe,
  output logic [WIDTH-1:0]      pad_out,
  output logic [WIDTH-1:0]      pad_pu,
  input  logic                  spi_en,
  input  logic                  spi_master,
  input  logic [WIDTH-1:0]      spi_claim,
  input  logic [WIDTH-1:0]      spi_oe,
  input  logic [WIDTH-1:0]      spi_out,
  output logic [WIDTH-1:0]      spi_in
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_d(pad_in), .sync_q(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
    .rd_valid(bus_rvalid), .rd_data(bus_rdata)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .SELECT_PIN(SELECT_PIN)) u_mux (
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
    .per_en(spi_en), .per_master(spi_master), .per_claim(spi_claim),
    .per_oe(spi_oe), .per_out(spi_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  assign spi_in = pin_sync;

  // R7: a pull-up never coincides with an enabled driver.
  p_pull_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
  // R6: slave mode forces the select pin to input.
  p_select_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> !pad_oe[SELECT_PIN]);
  // R6: otherwise the select pin follows its direction bit.
  p_select_gpio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_en || spi_master) |-> pad_oe[SELECT_PIN] == dir_q[SELECT_PIN]);
  // R2: with the peripheral off, every driver follows the direction register.
  p_dir_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |-> pad_oe == dir_q);
endmodule

// File: tb/gpio_port_ovr_test.sv
`timescale 1ns/100ps
module gpio_port_ovr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rvalid;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic       spi_en = 1'b0, spi_master = 1'b0;
  logic [7:0] spi_claim = '0, spi_oe = '0, spi_out = '0;
  logic [7:0] spi_in;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_port_ovr uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .spi_en(spi_en), .spi_master(spi_master), .spi_claim(spi_claim),
    .spi_oe(spi_oe), .spi_out(spi_out), .spi_in(spi_in)
  );

  typedef struct packed {
    logic [7:0] dir, dat, pue;
    logic       en, mst;
    logic [7:0] claim, poe, pout, pin;
    logic [7:0] e_oe, e_out, e_pu, e_rd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hA5, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'h00, 8'hA5},
    '{8'h00, 8'h3C, 8'h0F, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h96, 8'h00, 8'h3C, 8'h0F, 8'h96},
    '{8'hF0, 8'h5A, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hC3, 8'hF0, 8'h5A, 8'h0F, 8'h53},
    '{8'h0F, 8'hF0, 8'hFF, 1'b1, 1'b1, 8'h0E, 8'h06, 8'hFF, 8'hAA, 8'h07, 8'hFE, 8'hF8, 8'hA0},
    '{8'hFF, 8'h00, 8'h01, 1'b1, 1'b0, 8'h00, 8'hFF, 8'hFF, 8'h01, 8'hFE, 8'h00, 8'h01, 8'h00},
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h01, 8'hFF, 8'h00, 8'h5A, 8'h00, 8'hFF, 8'h00, 8'h5A},
    '{8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF}
  };

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rvalid; d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       rv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    bus_read(2'd1, rd, rv);
    chk("R1 dir readback", rd, 8'h00);
    bus_read(2'd2, rd, rv);
    chk("R1 pull readback", rd, 8'h00);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      spi_en = VECS[k].en; spi_master = VECS[k].mst;
      spi_claim = VECS[k].claim; spi_oe = VECS[k].poe; spi_out = VECS[k].pout;
      pad_in = VECS[k].pin;
      bus_write(2'd0, VECS[k].dat);
      bus_write(2'd1, VECS[k].dir);
      bus_write(2'd2, VECS[k].pue);
      chk($sformatf("R2/R5/R6 pad_oe vec %0d", k), pad_oe, VECS[k].e_oe);
      chk($sformatf("R2/R4/R5 pad_out vec %0d", k), pad_out, VECS[k].e_out);
      chk($sformatf("R7 pad_pu vec %0d", k), pad_pu, VECS[k].e_pu);
      bus_read(2'd0, rd, rv);
      chk($sformatf("R3 data readback vec %0d", k), rd, VECS[k].e_rd);
      if (VECS[k].en && !VECS[k].mst)
        chk($sformatf("R6 spi_in select bit vec %0d", k), {7'd0, spi_in[0]}, {7'd0, VECS[k].pin[0]});
    end

    // R8: two-edge synchroniser latency
    @(negedge clk);
    spi_en = 1'b0; spi_claim = '0; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h3C;
    @(negedge clk);
    chk("R8 spi_in after one edge", spi_in, 8'h00);
    @(negedge clk);
    chk("R8 spi_in after two edges", spi_in, 8'h3C);

    // R4: preload the latch while input, then enable the driver
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h81);
    chk("R4 pad_oe still off after preload", pad_oe, 8'h00);
    chk("R4 pad_out shows preload", pad_out, 8'h81);
    bus_write(2'd1, 8'hFF);
    chk("R4 pad_oe on", pad_oe, 8'hFF);
    chk("R4 pad_out first driven cycle", pad_out, 8'h81);

    // R9: read timing and the spare address
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, rd, rv);
    chk("R9 rvalid on read", {7'd0, rv}, 8'h01);
    chk("R9 spare reads zero", rd, 8'h00);
    @(negedge clk);
    chk("R9 rvalid drops", {7'd0, bus_rvalid}, 8'h00);
    bus_read(2'd0, rd, rv);
    chk("R9 spare write left latch", rd, 8'h81);

    // R10: register readback
    bus_write(2'd2, 8'h5A);
    bus_read(2'd2, rd, rv);
    chk("R10 pull readback", rd, 8'h5A);
    bus_write(2'd1, 8'hC6);
    bus_read(2'd1, rd, rv);
    chk("R10 dir readback", rd, 8'hC6);

    // R6: master mode returns the select pin to GPIO
    @(negedge clk);
    spi_en = 1'b1; spi_master = 1'b1; spi_claim = 8'h00;
    bus_write(2'd1, 8'h01);
    chk("R6 select pin driven as GPIO in master mode", pad_oe, 8'h01);
    @(negedge clk);
    spi_master = 1'b0;
    #1;
    chk("R6 select pin forced input in slave mode", pad_oe, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule